// File: doc/BRIEF.md
# Tagged Character Receive Ring Buffer

This block sits between a serial receive path and a single consumer. The receiver presents one character at a time on a write strobe, together with its hardware status word. The block stores the character and the low byte of that status as one tagged entry in a circular buffer. The consumer sees the oldest entry at all times and pops it with a read strobe. Empty and full flags come from comparing the two pointers. One slot always stays unused, so a full buffer is never confused with an empty one.

A character that arrives while the buffer is full is thrown away, and the overflow is recorded. A character whose status reports a parity, overrun or framing error is recorded as a fatal error. The recorded error is a sticky two-bit code that only the consumer's clear input removes. A fatal error takes precedence over an overflow. Every arriving character produces a one-cycle event pulse. That pulse presents the interrupt channel mask sampled with the character, so a zero mask raises no interrupt.

Top module: `rxring_top`

## Requirements
- R1: After reset `empty`=1, `full`=0, `err_code`=0, `evt`=0 and `irq_out`=0. `empty` is 1 exactly when the read and write pointers are equal.
- R2: With DEPTH slots, the buffer holds at most DEPTH-1 entries. `full` rises in the cycle after the (DEPTH-1)th unread entry is accepted.
- R3: `rd_word` shows the oldest unread entry while `empty`=0, coded as {status[7:0], data[7:0]} (tag in bits 15:8, character in bits 7:0). Entries come out in arrival order. The head changes only after an `rd_en` pop, taking effect at the next clock edge.
- R4: A write while `full`=1 leaves the stored entries unchanged. If the code was 0 after any clear, `err_code` becomes 2 at the next edge.
- R5: A write whose status has any bit of FATAL_MASK set makes `err_code` 1 at the next edge. With the default mask these are bits 0 (parity), 1 (overrun) and 2 (framing). The character itself is still stored if there is room.
- R6: `err_code` keeps its nonzero value until `err_clr`=1, which gives 0 at the next edge. If an error event occurs in the same cycle as `err_clr`, that event's code is loaded instead of 0.
- R7: Code 1 is never replaced by code 2. A fatal status replaces a held code 2 with code 1.
- R8: Both pointers wrap from slot DEPTH-1 to slot 0, including for DEPTH values that are not powers of two. FIFO order is kept across the wrap.
- R9: Each `wr_en` cycle, whether the character is accepted or dropped, gives `evt`=1 for exactly the next cycle. In that cycle `irq_out` equals the `irq_mask` sampled with the write. At all other times `irq_out` is 0.
- R10: `rd_en` while `empty`=1 has no effect: the pointers do not move, and a later write is the next entry read.
- R11: A write and a pop in the same cycle while `full`=1 drop the write and remove one entry, so `full` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Character arrival strobe |
| wr_data | input | 8 | Received character |
| wr_status | input | STAT_W | Hardware status accompanying the character |
| rd_en | input | 1 | Pop the head entry |
| rd_word | output | 16 | Head entry {status tag, character} |
| empty | output | 1 | No unread entry |
| full | output | 1 | DEPTH-1 unread entries |
| err_code | output | 2 | Sticky error: 0 none, 1 fatal status, 2 overflow |
| err_clr | input | 1 | Clear the error code |
| irq_mask | input | MASK_W | Interrupt channels to signal on each character |
| evt | output | 1 | Per-character event pulse |
| irq_out | output | MASK_W | Masked interrupt request |

## Verification
On every cycle the assertions check several behaviours. The flags are never both set. The head entry stays stable while no pop happens. A dropped write keeps the buffer full, and a pop on an empty buffer keeps it empty. The error code stays sticky, with code 1 keeping precedence. The pointers wrap at DEPTH-1. An interrupt appears only with an event. Only the bench's scenarios, run against a reference queue, can show the rest. That includes the contents and arrival order of the tags and characters across many wraps of a non-power-of-two buffer. It also includes exactly which code is loaded when a clear meets a new error in the same cycle.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
  localparam int unsigned CHAR_W = 8;
  localparam int unsigned TAG_W  = 8;
  localparam int unsigned ENTRY_W = CHAR_W + TAG_W;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_FATAL = 2'd1,
    ERR_FULL  = 2'd2
  } err_code_e;

  function automatic int unsigned ptr_width(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/rxring_ptr.sv
module rxring_ptr
  import rxring_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PW = ptr_width(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [PW-1:0] ptr
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [PW-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr;
    if (adv) ptr_d = (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr <= '0;
    else if (adv) ptr <= ptr_d;
  end

  // R8: wrap from the last slot back to slot 0
  a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && ptr == LAST) |=> (ptr == '0));
  a_r8_range: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= LAST);
endmodule

// File: rtl/rxring_store.sv
module rxring_store
  import rxring_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PW = ptr_width(DEPTH)
) (
  input  logic               clk,
  input  logic               we,
  input  logic [PW-1:0]      waddr,
  input  logic [ENTRY_W-1:0] wdata,
  input  logic [PW-1:0]      raddr,
  output logic [ENTRY_W-1:0] rdata
);
  logic [ENTRY_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < int'(DEPTH); i++) begin
      if (we && waddr == PW'(i)) mem_q[i] <= wdata;
    end
  end

  always_comb rdata = mem_q[raddr];
endmodule

// File: rtl/rxring_err.sv
module rxring_err
  import rxring_pkg::*;
#(
  parameter int unsigned STAT_W = 16,
  parameter int unsigned MASK_W = 4,
  parameter logic [STAT_W-1:0] FATAL_MASK = 'h7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_status,
  input  logic              drop,
  input  logic              clr,
  input  logic [MASK_W-1:0] irq_mask,
  output err_code_e         code,
  output logic              evt,
  output logic [MASK_W-1:0] irq
);
  logic              fatal;
  err_code_e         base, code_d;
  logic [MASK_W-1:0] irq_d;

  always_comb begin
    fatal  = wr_en && |(wr_status & FATAL_MASK);
    base   = clr ? ERR_NONE : code;
    code_d = base;
    if (fatal)                            code_d = ERR_FATAL;
    else if (drop && base == ERR_NONE)    code_d = ERR_FULL;
    irq_d  = wr_en ? irq_mask : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= ERR_NONE;
      evt  <= 1'b0;
      irq  <= '0;
    end else begin
      code <= code_d;
      evt  <= wr_en;
      irq  <= irq_d;
    end
  end

  // R6: code held until an explicit clear
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (code != ERR_NONE && !clr) |=> (code != ERR_NONE));
  // R7: fatal code wins over overflow
  a_r7_fatal_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (code == ERR_FATAL && !clr) |=> (code == ERR_FATAL));
  // R5: fatal status reaches the code next cycle
  a_r5_fatal_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && |(wr_status & FATAL_MASK)) |=> (code == ERR_FATAL));
  // R9: interrupt only together with the event pulse
  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (irq != '0) |-> evt);
  a_r9_evt_follows: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> evt);
endmodule

// File: rtl/rxring_top.sv
module rxring_top
  import rxring_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned STAT_W = 16,
  parameter int unsigned MASK_W = 4,
  parameter logic [STAT_W-1:0] FATAL_MASK = 'h7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic [STAT_W-1:0] wr_status,
  input  logic              rd_en,
  output logic [15:0]       rd_word,
  output logic              empty,
  output logic              full,
  output logic [1:0]        err_code,
  input  logic              err_clr,
  input  logic [MASK_W-1:0] irq_mask,
  output logic              evt,
  output logic [MASK_W-1:0] irq_out
);
  localparam int unsigned PW = ptr_width(DEPTH);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam int unsigned SYNC_STAGES = 2;

  // reset: asserted asynchronously, released on the clock
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[SYNC_STAGES-1];

  logic [PW-1:0] wr_ptr, rd_ptr, wr_inc;
  logic          push, pop, drop;
  logic [ENTRY_W-1:0] head;
  err_code_e     code;

  always_comb begin
    wr_inc = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
    empty  = (rd_ptr == wr_ptr);
    full   = (rd_ptr == wr_inc);
    push   = wr_en && !full;
    drop   = wr_en && full;
    pop    = rd_en && !empty;
  end

  rxring_ptr #(.DEPTH(DEPTH)) u_wr_ptr (
    .clk(clk), .rst_n(rst_core_n), .adv(push), .ptr(wr_ptr));

  rxring_ptr #(.DEPTH(DEPTH)) u_rd_ptr (
    .clk(clk), .rst_n(rst_core_n), .adv(pop), .ptr(rd_ptr));

  rxring_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .we(push), .waddr(wr_ptr),
    .wdata({wr_status[TAG_W-1:0], wr_data}),
    .raddr(rd_ptr), .rdata(head));

  rxring_err #(.STAT_W(STAT_W), .MASK_W(MASK_W), .FATAL_MASK(FATAL_MASK)) u_err (
    .clk(clk), .rst_n(rst_core_n), .wr_en(wr_en), .wr_status(wr_status),
    .drop(drop), .clr(err_clr), .irq_mask(irq_mask),
    .code(code), .evt(evt), .irq(irq_out));

  assign rd_word  = head;
  assign err_code = code;

  // R2: one slot always free, flags exclusive
  a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(empty && full));
  // R3: head stable without a pop
  a_r3_head_stable: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!empty && !rd_en) |=> $stable(rd_word));
  // R4: a dropped write keeps the buffer full
  a_r4_drop_keeps_full: assert property (@(posedge clk) disable iff (!rst_core_n)
    (wr_en && full && !rd_en) |=> full);
  // R10: pop on empty is ignored
  a_r10_empty_read: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rd_en && empty && !wr_en) |=> empty);
  // R11: write and pop while full leave room
  a_r11_full_rw: assert property (@(posedge clk) disable iff (!rst_core_n)
    (wr_en && rd_en && full) |=> !full);
endmodule

// File: tb/sim_rxring_top.sv
module sim_rxring_top;
  localparam int unsigned DEPTH = 6;
  localparam int unsigned CAP = DEPTH - 1;

  logic        clk, rst_n, wr_en, rd_en, err_clr, empty, full, evt;
  logic [7:0]  wr_data;
  logic [15:0] wr_status, rd_word;
  logic [1:0]  err_code;
  logic [3:0]  irq_mask, irq_out;

  int compared = 0, mismatched = 0;
  bit done = 0;

  rxring_top #(.DEPTH(DEPTH), .STAT_W(16), .MASK_W(4), .FATAL_MASK(16'h0007)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_status(wr_status), .rd_en(rd_en), .rd_word(rd_word), .empty(empty),
    .full(full), .err_code(err_code), .err_clr(err_clr), .irq_mask(irq_mask),
    .evt(evt), .irq_out(irq_out));

  initial clk = 0;
  always #10 clk = ~clk;

  // reference model
  logic [15:0] mq [64];
  int          m_head = 0, m_cnt = 0;
  logic [1:0]  m_err = 0;
  logic        m_evt = 0;
  logic [3:0]  m_irq = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    chk(req, "empty (R1)", 32'(empty), 32'(m_cnt == 0));
    chk(req, "full (R2)", 32'(full), 32'(m_cnt == CAP));
    if (m_cnt > 0) chk(req, "rd_word (R3)", 32'(rd_word), 32'(mq[m_head]));
    chk(req, "err_code (R6)", 32'(err_code), 32'(m_err));
    chk(req, "evt (R9)", 32'(evt), 32'(m_evt));
    chk(req, "irq_out (R9)", 32'(irq_out), 32'(m_irq));
  endtask

  task automatic step(input string req, input bit w, input logic [7:0] d,
                      input logic [15:0] s, input bit r, input bit c, input logic [3:0] m);
    bit m_full, m_empty, drop_m, acc, popm, fatal;
    logic [1:0] e;
    wr_en = w; wr_data = d; wr_status = s; rd_en = r; err_clr = c; irq_mask = m;
    m_full = (m_cnt == CAP); m_empty = (m_cnt == 0);
    drop_m = w && m_full; acc = w && !m_full; popm = r && !m_empty;
    fatal = w && ((s & 16'h0007) != 0);
    e = c ? 2'd0 : m_err;
    if (fatal) e = 2'd1;
    else if (drop_m && e == 2'd0) e = 2'd2;
    @(posedge clk);
    @(negedge clk);
    if (acc) begin
      mq[(m_head + m_cnt) % 64] = {s[7:0], d};
      m_cnt++;
    end
    if (popm) begin
      m_head = (m_head + 1) % 64;
      m_cnt--;
    end
    m_err = e; m_evt = w; m_irq = w ? m : 4'd0;
    wr_en = 0; rd_en = 0; err_clr = 0;
    compare_all(req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    rst_n = 0; wr_en = 0; rd_en = 0; err_clr = 0;
    wr_data = 0; wr_status = 0; irq_mask = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    compare_all("R1");

    // R10: pop on empty ignored, next write is the next entry read
    step("R10", 0, 8'h00, 16'h0000, 1, 0, 4'h0);
    step("R10", 1, 8'hA5, 16'h0038, 0, 0, 4'h0);
    step("R10", 0, 8'h00, 16'h0000, 1, 0, 4'h0);

    // R2: fill to capacity with non-fatal tags
    for (int i = 0; i < int'(CAP); i++)
      step("R2", 1, 8'(i * 17 + 3), 16'({i[4:0], 3'b000}), 0, 0, 4'h3);
    // R4: drop while full, overflow code
    step("R4", 1, 8'hEE, 16'h00F8, 0, 0, 4'b0101);
    step("R4", 1, 8'hEF, 16'h0008, 0, 0, 4'b0000);
    // R11: write and pop while full
    step("R11", 1, 8'h77, 16'h0010, 1, 0, 4'h1);
    // R3: drain in order
    while (m_cnt > 0) step("R3", 0, 8'h00, 16'h0000, 1, 0, 4'h0);
    // R6: clear
    step("R6", 0, 8'h00, 16'h0000, 0, 1, 4'h0);
    // R5: fatal character is stored and latches code 1
    step("R5", 1, 8'h5A, 16'h0002, 0, 0, 4'h8);
    step("R5", 0, 8'h00, 16'h0000, 1, 0, 4'h0);
    // R7: overflow does not replace code 1
    for (int i = 0; i < int'(CAP) + 1; i++)
      step("R7", 1, 8'(i + 40), 16'h0020, 0, 0, 4'h2);
    // R6: clear together with an overflow loads code 2
    step("R6", 1, 8'h11, 16'h0000, 0, 1, 4'h0);
    // R7: fatal replaces code 2 even when dropped
    step("R7", 1, 8'h12, 16'h0004, 0, 0, 4'h0);
    // R6: clear together with fatal keeps 1
    step("R6", 1, 8'h13, 16'h0001, 0, 1, 4'h0);
    while (m_cnt > 0) step("R3", 0, 8'h00, 16'h0000, 1, 0, 4'h0);
    step("R6", 0, 8'h00, 16'h0000, 0, 1, 4'h0);

    // R8: long sweep over many wraps of a non-power-of-two buffer
    for (int i = 0; i < 400; i++) begin
      bit w, r, c;
      logic [15:0] s;
      w = (i % 3) != 2;
      r = (i < 200) ? ((i % 2) == 0) : ((i % 4) != 0);
      c = (i % 17) == 0;
      s = ((i % 23) == 0) ? 16'h0001 << (i % 3) : 16'({i[4:0], 3'b000});
      step("R8", w, 8'(i * 7), s, r, c, 4'(i));
    end
    finish_run();
  end
endmodule